// File: doc/BRIEF.md
# Package-Granular Receive Port Scheduler

This block sits between a set of network receive ports and a single downstream consumer. Each port feeds 33-bit flits into its own small buffer. Each flit carries 32 payload bits and one end-of-package marker. The scheduler picks one port at a time and forwards that port's whole package, flit by flit, over a request/acknowledge handshake. It releases the port only after the flit that closes the package has been accepted. Packages from different ports are therefore never interleaved at the output.

Port 0 carries best-effort traffic and has a four-flit buffer. Ports 1 to N carry guaranteed-service traffic and each has a three-flit buffer. The guaranteed-service ports share a round-robin rotation. The best-effort port is chosen only when none of them has a package ready. A buffer offers a package once it is full or once it holds a closing flit. A package longer than its buffer therefore starts as soon as the buffer fills. It keeps the grant while the buffer refills.

Top module: `rx_pkt_sched`

## Requirements
- R1: A flit on port p occupies in_flit[p*33 +: 33]. Bits [31:0] are payload and bit 32 is the end-of-package (EOP) marker. At the output, the payload appears on out_data and the marker appears on out_eop.
- R2: The port 0 buffer holds 4 flits and each guaranteed-service buffer holds 3 flits. in_ready[p] is high exactly when buffer p is not full. A flit is stored only when in_valid[p] and in_ready[p] are both high at a clock edge.
- R3: A port is eligible for a grant only when its buffer is full or holds at least one EOP flit. An empty buffer is never eligible. With no eligible port, nothing is granted.
- R4: Once a port is granted, only that port's flits reach the output until its EOP flit has been accepted.
- R5: Guaranteed-service ports (indices 1..N) are granted in round-robin order. The rotation starts at port 1 after reset. After a package from port g completes, the search starts at port g+1, wrapping from N back to 1.
- R6: Port 0 is granted only when no guaranteed-service port is eligible.
- R7: out_req is high whenever a port is granted and its buffer is not empty. While out_req is high and out_ack is low, out_req, out_data and out_eop hold steady. A flit is consumed at each clock edge where out_req and out_ack are both high.
- R8: A package longer than its buffer keeps the grant while the buffer refills. out_req is low while the buffer is empty and rises again when the next flit arrives.
- R9: An active-low reset empties every buffer, clears the grant and returns the rotation to port 1. During reset out_req is low and every in_ready is high.
- R10: Flits from one port leave in the order in which they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_GS+1 | Per-port flit offered |
| in_flit | input | 33*(N_GS+1) | Per-port flit, port p at bits p*33 +: 33 |
| in_ready | output | N_GS+1 | Per-port buffer has room |
| out_req | output | 1 | Output flit valid |
| out_data | output | 32 | Output flit payload |
| out_eop | output | 1 | Output flit closes its package |
| out_ack | input | 1 | Consumer accepts the flit |

## Verification
The bench stresses a port that is offered a flit on the same edge its full buffer drains. A design that checked fullness after the pop would store a flit that should have been refused. Long packages with rare EOP markers test the refill rule: a scheduler that dropped the grant when the buffer emptied would splice another port's flits into the package. Sustained guaranteed-service load checks that port 0 stays starved. A stalled consumer checks that payload is held. A rotation pointer advanced at grant time, or left alone, shows up as a payload mismatch against the reference queues. One mid-run reset confirms that buffered flits and the rotation are discarded.

// File: rtl/rx_sched_pkg.sv
package rx_sched_pkg;
  // next rotation start after guaranteed-service port g finished (ports 1..n_gs)
  function automatic int unsigned rr_after(int unsigned g, int unsigned n_gs);
    return (g >= n_gs) ? 1 : g + 1;
  endfunction

  // buffer depth for a port index
  function automatic int unsigned port_depth(int unsigned p, int unsigned be_d, int unsigned gs_d);
    return (p == 0) ? be_d : gs_d;
  endfunction
endpackage

// File: rtl/rx_flit_buf.sv
module rx_flit_buf #(
  parameter int W     = 33,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic         pkt_rdy
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, eop_cnt;

  assign dout    = mem[rd_ptr];
  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign pkt_rdy = full || (eop_cnt != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      eop_cnt <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt     <= cnt + CW'(push) - CW'(pop);
      eop_cnt <= eop_cnt + CW'(push && din[W-1]) - CW'(pop && dout[W-1]);
    end
  end

  // R3: a buffer that offers a package is never empty
  p_rdy_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rdy |-> !empty);
endmodule

// File: rtl/rx_pkg_arb.sv
module rx_pkg_arb
  import rx_sched_pkg::*;
#(
  parameter int N_GS = 3,
  localparam int NP  = N_GS + 1,
  localparam int IW  = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] rdy,
  input  logic          xfer,
  input  logic          xfer_eop,
  output logic          busy,
  output logic [IW-1:0] gnt
);
  logic [IW-1:0]   rr_q, pick;
  logic            found;
  logic [N_GS-1:0] gs_rdy;
  logic            pkt_done;

  assign gs_rdy   = rdy[NP-1:1];
  assign pkt_done = busy && xfer && xfer_eop;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N_GS; k++) begin
      int idx;
      idx = int'(rr_q) - 1 + k;
      if (idx >= N_GS) idx = idx - N_GS;
      if (!found && gs_rdy[idx]) begin
        found = 1'b1;
        pick  = IW'(idx + 1);
      end
    end
    if (!found && rdy[0]) begin
      found = 1'b1;
      pick  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      gnt  <= '0;
      rr_q <= IW'(1);
    end else if (busy) begin
      if (pkt_done) begin
        busy <= 1'b0;
        if (gnt != '0) rr_q <= IW'(rr_after(int'(gnt), N_GS));
      end
    end else if (found) begin
      busy <= 1'b1;
      gnt  <= pick;
    end
  end

  // R4: grant holds until the closing flit is accepted
  p_grant_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pkt_done) |=> (busy && $stable(gnt)));
  // R6: best-effort port loses to any eligible guaranteed-service port
  p_be_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (gs_rdy != '0)) |=> (busy && gnt != '0));
  // R3: no eligible port, no grant
  p_no_rdy_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (rdy == '0)) |=> !busy);
endmodule

// File: rtl/rx_pkt_sched.sv
module rx_pkt_sched
  import rx_sched_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int N_GS     = 3,
  parameter int BE_DEPTH = 4,
  parameter int GS_DEPTH = 3,
  localparam int NP      = N_GS + 1,
  localparam int FW      = DATA_W + 1,
  localparam int IW      = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*FW-1:0] in_flit,
  output logic [NP-1:0]    in_ready,
  output logic             out_req,
  output logic [DATA_W-1:0] out_data,
  output logic             out_eop,
  input  logic             out_ack
);
  logic [FW-1:0] head [NP];
  logic [NP-1:0] full, empty, rdy, pop;
  logic          busy, xfer;
  logic [IW-1:0] gnt;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int D = int'(port_depth(p, BE_DEPTH, GS_DEPTH));
    rx_flit_buf #(.W(FW), .DEPTH(D)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (in_valid[p] && !full[p]),
      .pop     (pop[p]),
      .din     (in_flit[p*FW +: FW]),
      .dout    (head[p]),
      .full    (full[p]),
      .empty   (empty[p]),
      .pkt_rdy (rdy[p])
    );
    assign pop[p]      = xfer && (gnt == IW'(p));
    assign in_ready[p] = !full[p];
  end

  rx_pkg_arb #(.N_GS(N_GS)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy      (rdy),
    .xfer     (xfer),
    .xfer_eop (out_eop),
    .busy     (busy),
    .gnt      (gnt)
  );

  assign out_req  = busy && !empty[gnt];
  assign xfer     = out_req && out_ack;
  assign out_data = head[gnt][DATA_W-1:0];
  assign out_eop  = head[gnt][FW-1];

  // R7: an unaccepted flit is held unchanged
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> (out_req && $stable(out_data) && $stable(out_eop)));
endmodule

// File: tb/sim_rx_pkt_sched.sv
module sim_rx_pkt_sched;
  localparam int CLK_P = 10;
  localparam int NGS   = 3;
  localparam int NP    = NGS + 1;
  localparam int FW    = 33;

  logic             clk = 0;
  logic             rst_n = 0;
  logic [NP-1:0]    in_valid = '0;
  logic [NP*FW-1:0] in_flit = '0;
  logic [NP-1:0]    in_ready;
  logic             out_req;
  logic [31:0]      out_data;
  logic             out_eop;
  logic             out_ack = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  rx_pkt_sched u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  // reference model state
  logic [FW-1:0] q [NP][$];
  bit m_busy;
  int m_g, m_rr;

  function automatic int dep(int p);
    return (p == 0) ? 4 : 3;
  endfunction

  function automatic bit m_rdy(int p);
    if (q[p].size() == dep(p)) return 1;
    foreach (q[p][i]) if (q[p][i][32]) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < NP; p++) q[p].delete();
    m_busy = 0; m_g = 0; m_rr = 1;
  endtask

  task automatic compare();
    bit er;
    er = m_busy && (q[m_g].size() > 0);
    chk("R7 R8 out_req", 64'(out_req), 64'(er));
    if (er) begin
      chk("R4 R5 R6 R10 out_data", 64'(out_data), 64'(q[m_g][0][31:0]));
      chk("R1 out_eop", 64'(out_eop), 64'(q[m_g][0][32]));
    end
    for (int p = 0; p < NP; p++)
      chk("R2 in_ready", 64'(in_ready[p]), 64'(q[p].size() < dep(p)));
  endtask

  task automatic step(int vr, int er, int ar);
    bit was_full [NP];
    logic [FW-1:0] f;
    @(negedge clk);
    compare();
    for (int p = 0; p < NP; p++) begin
      in_valid[p] = (($urandom % 100) < vr);
      in_flit[p*FW +: FW] = {(($urandom % 100) < er) ? 1'b1 : 1'b0, 32'($urandom)};
      was_full[p] = (q[p].size() >= dep(p));
    end
    out_ack = (($urandom % 100) < ar);
    if (m_busy) begin
      if (q[m_g].size() > 0 && out_ack) begin
        f = q[m_g].pop_front();
        if (f[32]) begin
          m_busy = 0;
          if (m_g != 0) m_rr = (m_g == NGS) ? 1 : m_g + 1;
        end
      end
    end else begin
      for (int k = 0; k < NGS; k++) begin
        int idx;
        idx = ((m_rr - 1 + k) % NGS) + 1;
        if (!m_busy && m_rdy(idx)) begin m_busy = 1; m_g = idx; end
      end
      if (!m_busy && m_rdy(0)) begin m_busy = 1; m_g = 0; end
    end
    for (int p = 0; p < NP; p++)
      if (in_valid[p] && !was_full[p]) q[p].push_back(in_flit[p*FW +: FW]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = '0; out_ack = 0;
    model_clear();
    @(negedge clk);
    // R9: reset state
    chk("R9 out_req", 64'(out_req), 64'(0));
    chk("R9 in_ready", 64'(in_ready), 64'({NP{1'b1}}));
    rst_n = 1;
  endtask

  initial begin
    model_clear();
    do_reset();
    for (int i = 0; i < 3000; i++) step(60, 30, 70);
    for (int i = 0; i < 3000; i++) step(90, 10, 100);
    do_reset();
    for (int i = 0; i < 3000; i++) step(30, 50, 40);
    for (int i = 0; i < 3000; i++) step(80, 5, 20);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule